// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the strobes and port values with which an 8051-style core reaches off-chip program and data memory. Each clock period of the block is one oscillator period. The bus runs in slots of six clocks. A program fetch fills one slot. An external data access fills a full machine cycle of twelve clocks. The low address byte and the data byte share one 8-bit port. An external latch captures the low address on the falling edge of the address-latch strobe. A second port carries the high address byte.

The core places level requests: a fetch with its program counter, or a data access. A data access carries either a 16-bit pointer or an 8-bit indirect address. The sequencer reads these requests on the last clock of every slot and starts at most one access. Data accesses win over fetches. A code-select input and a fixed on-chip code size decide whether a fetch goes out on the bus or stays local. The byte read from the bus comes back with a one-clock valid pulse.

Top module: `extBusSeq`

## Requirements
- R1: While `rstN` is low, `ale` is 0, `psenN`, `rdN` and `wrN` are 1, `p0Oe` is 0 and `rdValid` is 0.
- R2: `ale` is high for the first two clocks of every six-clock slot, counting from clock 0 of the slot. In a twelve-clock data access it is high only in clocks 0 and 1, and the pulse at clocks 6 and 7 is left out.
- R3: In an external fetch slot, `p0Out` carries PC[7:0] with `p0Oe`=1 in clocks 0 to 2. `psenN` is low in clocks 3 to 5 with `p0Oe`=0. `p2Out` carries PC[15:8] in all six clocks.
- R4: A fetch is local when `extCodeSel`=1 and PC < 0x2000. Every other fetch is external, and with `extCodeSel`=0 all fetches are external. In a local fetch slot, `psenN` stays 1, `p0Oe` is 0, `fetchLocal` is 1 and no `rdValid` follows.
- R5: `p0In` is sampled on the last clock edge of the `psenN`-low or `rdN`-low window. `rdValid` is high for exactly the one clock after that edge, and `rdByte` holds the sampled byte.
- R6: A data read runs twelve clocks. `rdN` is low in clocks 3 to 10, `psenN` stays 1 in all twelve, and `p0Oe` is 1 in clocks 0 to 2 only, with the address low byte.
- R7: A data write runs twelve clocks. `wrN` is low in clocks 3 to 10, and `p0Out` carries the write byte with `p0Oe`=1 in clocks 3 to 11.
- R8: For a data access with `dataWide`=1, `p2Out` carries address bits 15:8. With `dataWide`=0, `p2Out` carries the `p2Sfr` input, and only `dataAddr[7:0]` appears on `p0Out`.
- R9: When both requests are present at a slot end, the data access is started. When neither is present, the slot is idle: `ale` still pulses, all three strobes stay 1, `p0Oe` is 0 and `p2Out` equals `p2Sfr`.
- R10: `reqTaken` is 1 in clock 0 of each started access, local or external, and 0 in every other clock. The requester drops the request before that slot ends.
- R11: At most one of `psenN`, `rdN` and `wrN` is low at any time, and none of them is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| extCodeSel | input | 1 | 1 = low code space on chip, 0 = all code external |
| fetchReq | input | 1 | Fetch request level |
| fetchPc | input | 16 | Program counter for the fetch |
| dataReq | input | 1 | External data access request level |
| dataWrite | input | 1 | 1 = write, 0 = read |
| dataWide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit indirect address |
| dataAddr | input | 16 | Data address (bits 7:0 only when narrow) |
| dataWdata | input | 8 | Byte to write |
| p2Sfr | input | 8 | Current port-2 register value |
| p0In | input | 8 | Value read back from the shared port |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| p0Out | output | 8 | Shared port drive value |
| p0Oe | output | 1 | Shared port drive enable (0 = released) |
| p2Out | output | 8 | High address port value |
| reqTaken | output | 1 | An access starts in this clock |
| fetchLocal | output | 1 | The current slot is a local fetch |
| rdByte | output | 8 | Last byte read from the bus |
| rdValid | output | 1 | `rdByte` was captured at the previous edge |

## Verification
The hardest case to reach is a slot end where both a fetch and a data request are pending. A requester that follows the protocol drops each request once it is taken, so the two rarely overlap by accident. The bench builds this case on purpose: it holds a fetch request and raises a data read at the same time. It then checks that the access which follows lasts twelve clocks, with `rdN` low and `psenN` high. The code-space split is swept at both sides of the 0x2000 boundary and at the ends of the address range, with each setting of `extCodeSel`.

// File: rtl/extBusPkg.sv
package extBusPkg;

  typedef enum logic [2:0] {
    K_IDLE,
    K_FETCH_EXT,
    K_FETCH_LOC,
    K_DATA_RD,
    K_DATA_WR
  } accKind_t;

  typedef struct packed {
    logic ale;
    logic psenN;
    logic rdN;
    logic wrN;
    logic driveAddr;
    logic driveData;
    logic sample;
    logic p2Addr;
    logic loadFetch;
    logic loadData;
  } busStrobe_t;

endpackage

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int STATE_CLKS    = 2,
  parameter int LOC_CODE_SIZE = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extCodeSel,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              dataReq,
  input  logic              dataWrite,
  output busStrobe_t        stb,
  output logic              reqTaken,
  output logic              fetchLocal
);

  localparam int SLOT_LEN     = 3 * STATE_CLKS;
  localparam int CYCLE_LEN    = 2 * SLOT_LEN;
  localparam int PH_W         = $clog2(CYCLE_LEN);
  localparam int ADDR_END     = STATE_CLKS + STATE_CLKS / 2;
  localparam int DATA_STB_END = CYCLE_LEN - 1 - STATE_CLKS / 2;

  accKind_t kind, nextKind;
  logic [PH_W-1:0] ph, lastPh, stbEnd;
  logic isData, atEnd, localHit, strobeWin;

  assign isData   = (kind == K_DATA_RD) || (kind == K_DATA_WR);
  assign lastPh   = isData ? PH_W'(CYCLE_LEN - 1) : PH_W'(SLOT_LEN - 1);
  assign stbEnd   = isData ? PH_W'(DATA_STB_END) : PH_W'(SLOT_LEN - 1);
  assign atEnd    = (ph == lastPh);
  assign localHit = extCodeSel && ({1'b0, fetchPc} < (ADDR_W + 1)'(LOC_CODE_SIZE));

  always_comb begin
    if (dataReq)       nextKind = dataWrite ? K_DATA_WR : K_DATA_RD;
    else if (fetchReq) nextKind = localHit ? K_FETCH_LOC : K_FETCH_EXT;
    else               nextKind = K_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind <= K_IDLE;
      ph   <= PH_W'(SLOT_LEN - 1);
    end else if (atEnd) begin
      kind <= nextKind;
      ph   <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign strobeWin = (ph >= PH_W'(ADDR_END)) && (ph <= stbEnd);

  always_comb begin
    stb.ale       = (ph < PH_W'(STATE_CLKS));
    stb.psenN     = !((kind == K_FETCH_EXT) && strobeWin);
    stb.rdN       = !((kind == K_DATA_RD) && strobeWin);
    stb.wrN       = !((kind == K_DATA_WR) && strobeWin);
    stb.driveAddr = ((kind == K_FETCH_EXT) || isData) && (ph < PH_W'(ADDR_END));
    stb.driveData = (kind == K_DATA_WR) && (ph >= PH_W'(ADDR_END));
    stb.sample    = ((kind == K_FETCH_EXT) || (kind == K_DATA_RD)) && (ph == stbEnd);
    stb.p2Addr    = (kind == K_FETCH_EXT) || isData;
    stb.loadFetch = atEnd && ((nextKind == K_FETCH_EXT) || (nextKind == K_FETCH_LOC));
    stb.loadData  = atEnd && ((nextKind == K_DATA_RD) || (nextKind == K_DATA_WR));
  end

  assign reqTaken   = (kind != K_IDLE) && (ph == '0);
  assign fetchLocal = (kind == K_FETCH_LOC);

endmodule

// File: rtl/extBusDp.sv
module extBusDp
  import extBusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              dataWide,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataWdata,
  input  logic [DATA_W-1:0] p2Sfr,
  input  logic [DATA_W-1:0] p0In,
  output logic [DATA_W-1:0] p0Out,
  output logic              p0Oe,
  output logic [DATA_W-1:0] p2Out,
  output logic [DATA_W-1:0] rdByte,
  output logic              rdValid
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdReg;
  logic              wideReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      wdReg   <= '0;
      wideReg <= 1'b0;
      rdByte  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.loadFetch) begin
        addrReg <= fetchPc;
        wideReg <= 1'b1;
      end else if (stb.loadData) begin
        addrReg <= dataWide ? dataAddr : {{HI_W{1'b0}}, dataAddr[DATA_W-1:0]};
        wdReg   <= dataWdata;
        wideReg <= dataWide;
      end
      rdValid <= stb.sample;
      if (stb.sample) rdByte <= p0In;
    end
  end

  assign p0Oe  = stb.driveAddr || stb.driveData;
  assign p0Out = stb.driveAddr ? addrReg[DATA_W-1:0] : (stb.driveData ? wdReg : '0);
  assign p2Out = (stb.p2Addr && wideReg) ? addrReg[ADDR_W-1:DATA_W] : p2Sfr;

endmodule

// File: rtl/extBusSeq.sv
module extBusSeq
  import extBusPkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int STATE_CLKS    = 2,
  parameter int LOC_CODE_SIZE = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extCodeSel,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              dataReq,
  input  logic              dataWrite,
  input  logic              dataWide,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataWdata,
  input  logic [DATA_W-1:0] p2Sfr,
  input  logic [DATA_W-1:0] p0In,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] p0Out,
  output logic              p0Oe,
  output logic [DATA_W-1:0] p2Out,
  output logic              reqTaken,
  output logic              fetchLocal,
  output logic [DATA_W-1:0] rdByte,
  output logic              rdValid
);

  busStrobe_t stb;

  extBusCtrl #(
    .ADDR_W(ADDR_W), .STATE_CLKS(STATE_CLKS), .LOC_CODE_SIZE(LOC_CODE_SIZE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .extCodeSel(extCodeSel), .fetchReq(fetchReq),
    .fetchPc(fetchPc), .dataReq(dataReq), .dataWrite(dataWrite),
    .stb(stb), .reqTaken(reqTaken), .fetchLocal(fetchLocal)
  );

  extBusDp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .fetchPc(fetchPc), .dataWide(dataWide),
    .dataAddr(dataAddr), .dataWdata(dataWdata), .p2Sfr(p2Sfr), .p0In(p0In),
    .p0Out(p0Out), .p0Oe(p0Oe), .p2Out(p2Out), .rdByte(rdByte), .rdValid(rdValid)
  );

  assign ale   = stb.ale;
  assign psenN = stb.psenN;
  assign rdN   = stb.rdN;
  assign wrN   = stb.wrN;

endmodule

// File: rtl/extBusSeqChk.sv
module extBusSeqChk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic psenN,
  input logic rdN,
  input logic wrN,
  input logic p0Oe,
  input logic rdValid
);

  a_r2_ale_two_clocks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |=> ale ##1 !ale);

  a_r3_psen_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    !psenN |-> !p0Oe);

  a_r6_rd_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !p0Oe);

  a_r7_wr_drives_bus: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> p0Oe);

  a_r5_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($rose(psenN) || $rose(rdN)));

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!psenN, !rdN, !wrN}) <= 1);

  a_r11_ale_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (psenN && rdN && wrN));

endmodule

bind extBusSeq extBusSeqChk chk_i (
  .clk(clk), .rstN(rstN), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
  .p0Oe(p0Oe), .rdValid(rdValid)
);

// File: tb/extBusSeq_tb.sv
module extBusSeq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extCodeSel = 1'b0, fetchReq = 1'b0, dataReq = 1'b0;
  logic dataWrite = 1'b0, dataWide = 1'b0;
  logic [15:0] fetchPc = '0, dataAddr = '0;
  logic [7:0] dataWdata = '0, p2Sfr = 8'h3C, p0In = '0;
  logic ale, psenN, rdN, wrN, p0Oe, reqTaken, fetchLocal, rdValid;
  logic [7:0] p0Out, p2Out, rdByte;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  extBusSeq dut_i (
    .clk(clk), .rstN(rstN), .extCodeSel(extCodeSel), .fetchReq(fetchReq),
    .fetchPc(fetchPc), .dataReq(dataReq), .dataWrite(dataWrite), .dataWide(dataWide),
    .dataAddr(dataAddr), .dataWdata(dataWdata), .p2Sfr(p2Sfr), .p0In(p0In),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .p0Out(p0Out), .p0Oe(p0Oe),
    .p2Out(p2Out), .reqTaken(reqTaken), .fetchLocal(fetchLocal),
    .rdByte(rdByte), .rdValid(rdValid)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic waitTaken(input string tag);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (reqTaken) return;
    end
    chk(tag, "reqTaken never seen", 16'd0, 16'd1);
  endtask

  task automatic doFetch(input logic [15:0] pc, input logic ext, input logic [7:0] byteIn);
    logic loc;
    loc = ext && (pc < 16'h2000);
    p0In = byteIn; extCodeSel = ext; fetchPc = pc; fetchReq = 1'b1;
    waitTaken("R10");
    fetchReq = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2", "ale fetch", 16'(ale), 16'(k < 2));
      if (k == 1) chk("R10", "reqTaken clock1", 16'(reqTaken), 16'd0);
      if (loc) begin
        chk("R4", "psenN local", 16'(psenN), 16'd1);
        chk("R4", "p0Oe local", 16'(p0Oe), 16'd0);
        chk("R4", "fetchLocal", 16'(fetchLocal), 16'd1);
      end else begin
        chk("R3", "psenN ext", 16'(psenN), 16'(!(k >= 3)));
        chk("R3", "p0Oe ext", 16'(p0Oe), 16'(k < 3));
        chk("R4", "fetchLocal ext", 16'(fetchLocal), 16'd0);
        chk("R3", "p2Out ext", 16'(p2Out), 16'(pc[15:8]));
        if (k < 3) chk("R3", "p0Out addr", 16'(p0Out), 16'(pc[7:0]));
      end
    end
    @(negedge clk);
    chk(loc ? "R4" : "R5", "rdValid after fetch", 16'(rdValid), 16'(!loc));
    if (!loc) chk("R5", "rdByte fetch", 16'(rdByte), 16'(byteIn));
  endtask

  task automatic doData(input logic [15:0] addr, input logic wr, input logic wide,
                        input logic [7:0] wd, input logic [7:0] byteIn, input logic withFetch);
    p0In = byteIn; dataAddr = addr; dataWrite = wr; dataWide = wide; dataWdata = wd;
    if (withFetch) begin
      fetchPc = 16'h8000; extCodeSel = 1'b0; fetchReq = 1'b1;
    end
    dataReq = 1'b1;
    waitTaken("R10");
    dataReq = 1'b0;
    fetchReq = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2", "ale data", 16'(ale), 16'(k < 2));
      chk("R6", "psenN data", 16'(psenN), 16'd1);
      chk(wr ? "R7" : "R6", "rdN", 16'(rdN), 16'(!(!wr && k >= 3 && k <= 10)));
      chk(wr ? "R7" : "R6", "wrN", 16'(wrN), 16'(!(wr && k >= 3 && k <= 10)));
      chk(wr ? "R7" : "R6", "p0Oe data", 16'(p0Oe), 16'((k < 3) || (wr && k >= 3)));
      if (k < 3) chk("R8", "p0Out addr low", 16'(p0Out), 16'(addr[7:0]));
      else if (wr) chk("R7", "p0Out wdata", 16'(p0Out), 16'(wd));
      chk("R8", "p2Out data", 16'(p2Out), 16'(wide ? addr[15:8] : p2Sfr));
      if (withFetch && k == 11) chk("R9", "data won over fetch", 16'(rdN), 16'd1);
      if (withFetch && k == 5) chk("R9", "data strobe in priority", 16'(rdN), 16'd0);
      if (!wr && k == 11) begin
        chk("R5", "rdValid data", 16'(rdValid), 16'd1);
        chk("R5", "rdByte data", 16'(rdByte), 16'(byteIn));
      end
      if (!wr && k == 10) chk("R5", "rdValid early", 16'(rdValid), 16'd0);
    end
  endtask

  task automatic doIdle();
    int aleCnt;
    aleCnt = 0;
    repeat (14) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (ale) aleCnt++;
      chk("R9", "idle strobes", 16'({psenN, rdN, wrN}), 16'b111);
      chk("R9", "idle p0Oe", 16'(p0Oe), 16'd0);
      chk("R10", "idle reqTaken", 16'(reqTaken), 16'd0);
      chk("R9", "idle p2Out", 16'(p2Out), 16'(p2Sfr));
    end
    chk("R9", "idle ale clocks", 16'(aleCnt), 16'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pcs [6];
    pcs = '{16'h0000, 16'h1FFF, 16'h2000, 16'hFFFF, 16'h1234, 16'hA5C3};
    repeat (3) @(negedge clk);
    chk("R1", "reset ale", 16'(ale), 16'd0);
    chk("R1", "reset strobes", 16'({psenN, rdN, wrN}), 16'b111);
    chk("R1", "reset p0Oe", 16'(p0Oe), 16'd0);
    chk("R1", "reset rdValid", 16'(rdValid), 16'd0);
    rstN = 1'b1;

    doIdle();
    for (int e = 0; e < 2; e++)
      for (int i = 0; i < 6; i++)
        doFetch(pcs[i], 1'(e), 8'(pcs[i][7:0] ^ 8'h96 ^ 8'(i)));

    p2Sfr = 8'h5A;
    doData(16'hABCD, 1'b0, 1'b1, 8'h00, 8'hE1, 1'b0);
    doData(16'h7742, 1'b0, 1'b0, 8'h00, 8'h1E, 1'b0);
    doData(16'h1357, 1'b1, 1'b1, 8'hC4, 8'h00, 1'b0);
    doData(16'hFF09, 1'b1, 1'b0, 8'h3B, 8'h00, 1'b0);
    doData(16'h4466, 1'b0, 1'b1, 8'h00, 8'h77, 1'b1);
    p2Sfr = 8'hA7;
    doIdle();
    doFetch(16'h2001, 1'b1, 8'h55);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule